// File: doc/BRIEF.md
# OUT Endpoint Transfer Completion Tracker

This block sits beside the packet engine of a control OUT endpoint and decides when a host-to-device transfer has ended. For every packet the engine reports as good, it compares the packet's byte count with the configured maximum packet size. A packet shorter than the maximum ends the transfer. A zero-length packet also ends it, whether or not full-size packets came before it. Once a transfer has ended, the block tells the packet engine to answer every further OUT packet with NAK. This lasts until software acknowledges the end-of-transfer flag.

The block keeps a running total of the bytes accepted in the current transfer, so software can read how much data is waiting before it acknowledges. It also watches the receive FIFO fill level against a programmable threshold and flags each upward crossing. Three sticky status flags (end of packet, end of transfer, threshold) are cleared by writing ones and are gated by a mask into interrupt lines. A bus-reset event aborts the transfer in progress.

Top module: `out_xfer_tracker`

## Requirements
- R1: After reset, `flags`, `irq` and `rem_bytes` are all zero and `force_nak` is low.
- R2: A `pkt_good` strobe that is accepted (not NAKed and not during `bus_reset`) sets `flags[0]` (end of packet) on the following clock edge.
- R3: An accepted packet with `pkt_len` below `max_pkt` sets `flags[1]` (end of transfer). This covers short packets and zero-length packets, with or without earlier full-size packets.
- R4: An accepted packet with `pkt_len` equal to or above `max_pkt` leaves `flags[1]` clear.
- R5: `force_nak` is high exactly while `flags[1]` is set. A `pkt_good` strobe arriving while it is high changes neither `flags[0]` nor `rem_bytes`.
- R6: `rem_bytes` holds the sum of `pkt_len` over the packets accepted since the last end-of-transfer acknowledge or bus reset. The sum saturates at all ones and stays readable while `flags[1]` is pending.
- R7: A one in `clr_w1c[i]` clears `flags[i]` on the next edge, and a zero leaves it alone. When a set and a clear of the same bit coincide, the set wins. Acknowledging `flags[1]` also zeroes `rem_bytes`.
- R8: `flags[2]` is set on the edge where `fifo_level > thr_level` becomes true after having been false. A level that stays above the threshold does not set the flag again after it has been cleared.
- R9: `irq` equals `flags` bitwise ANDed with `irq_mask`.
- R10: `bus_reset` clears `flags[1]` and zeroes `rem_bytes` on the next edge, overrides a coincident `pkt_good`, and leaves `flags[0]` and `flags[2]` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | One-cycle bus reset event from the line monitor |
| pkt_good | input | 1 | One-cycle strobe: an OUT packet was received without error |
| pkt_len | input | LEN_W | Byte count of the strobed packet |
| max_pkt | input | LEN_W | Configured maximum packet size, nonzero |
| fifo_level | input | LVL_W | Current receive FIFO fill level |
| thr_level | input | LVL_W | Programmed FIFO threshold |
| irq_mask | input | 3 | Interrupt enable per flag |
| clr_w1c | input | 3 | Write-one-to-clear strobes per flag |
| flags | output | 3 | Sticky flags: bit 0 end of packet, bit 1 end of transfer, bit 2 threshold |
| irq | output | 3 | Masked flags |
| force_nak | output | 1 | Tells the packet engine to NAK further OUT packets |
| rem_bytes | output | CNT_W | Bytes accepted in the current transfer |

## Verification
A wrong end-of-transfer state shows at the ports in two ways. `force_nak` fails to follow `flags[1]`, and NAKed packets start moving `rem_bytes` or `flags[0]`. Both are visible one edge after the offending strobe. A stale byte total survives an acknowledge or a bus reset, and it appears in `rem_bytes` on the next edge. A threshold detector that compares levels instead of edges re-raises `flags[2]` one edge after software clears it while the level stays high. The bench predicts every cycle from its own model, so each of these faults is caught in the cycle it first appears.

// File: rtl/otx_pkg.sv
// Shared constants for the OUT transfer tracker: flag positions and count.
package otx_pkg;
    localparam int FLAG_N = 3;
    localparam int F_EOP  = 0;
    localparam int F_EOT  = 1;
    localparam int F_THR  = 2;
endpackage

// File: rtl/otx_flag_bit.sv
// One sticky status bit: set has priority over a write-one clear.
// Assumes set and clr are single-cycle qualified pulses.
module otx_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag until cleared; a coincident set keeps it high.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/otx_level_watch.sv
// Detects the cycle where the FIFO level rises above the threshold.
// Assumes level and threshold are stable, synchronous inputs.
module otx_level_watch #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    output logic             rise
);
    logic above, above_q;

    // Compare current level against the programmed threshold.
    always_comb above = (level > thresh);

    // Remember last comparison so only an upward crossing counts.
    always_ff @(posedge clk) begin
        if (!rst_n) above_q <= 1'b0;
        else        above_q <= above;
    end

    // Pulse on the false-to-true transition of the comparison.
    always_comb rise = above & ~above_q;
endmodule

// File: rtl/otx_xfer_judge.sv
// Qualifies incoming packets, classifies short ones and totals the bytes
// of the current transfer. Assumes max_pkt is nonzero and CNT_W >= LEN_W.
module otx_xfer_judge #(
    parameter int LEN_W = 7,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_good,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] max_pkt,
    input  logic             eot_pending,
    input  logic             eot_ack,
    input  logic             bus_reset,
    output logic             accept,
    output logic             ends_xfer,
    output logic [CNT_W-1:0] byte_cnt
);
    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum;

    // A packet counts only when not NAKed and not hit by a bus reset.
    always_comb accept = pkt_good & ~eot_pending & ~bus_reset;

    // Short or zero-length packets close the transfer.
    always_comb ends_xfer = accept & (pkt_len < max_pkt);

    // Widened sum for saturation detection.
    always_comb sum = {1'b0, byte_cnt} + SUM_W'(pkt_len);

    // Running byte total, cleared on acknowledge or bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                     byte_cnt <= '0;
        else if (bus_reset || eot_ack)  byte_cnt <= '0;
        else if (accept)                byte_cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
endmodule

// File: rtl/out_xfer_tracker.sv
// Top: decides end of OUT transfers, forces NAK while the end is pending,
// and keeps masked sticky flags. Assumes all inputs are synchronous to clk.
module out_xfer_tracker #(
    parameter int LEN_W = 7,
    parameter int LVL_W = 8,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             pkt_good,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] max_pkt,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] thr_level,
    input  logic [2:0]       irq_mask,
    input  logic [2:0]       clr_w1c,
    output logic [2:0]       flags,
    output logic [2:0]       irq,
    output logic             force_nak,
    output logic [CNT_W-1:0] rem_bytes
);
    import otx_pkg::*;

    logic              accept, ends_xfer, lvl_rise, eot_ack;
    logic [FLAG_N-1:0] set_v, clr_v;

    // Software acknowledge of a pending end of transfer.
    always_comb eot_ack = clr_w1c[F_EOT] & flags[F_EOT];

    otx_xfer_judge #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_good   (pkt_good),
        .pkt_len    (pkt_len),
        .max_pkt    (max_pkt),
        .eot_pending(flags[F_EOT]),
        .eot_ack    (eot_ack),
        .bus_reset  (bus_reset),
        .accept     (accept),
        .ends_xfer  (ends_xfer),
        .byte_cnt   (rem_bytes)
    );

    otx_level_watch #(.LVL_W(LVL_W)) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .level (fifo_level),
        .thresh(thr_level),
        .rise  (lvl_rise)
    );

    // Collect set and clear requests per flag bit.
    always_comb begin
        set_v        = '0;
        set_v[F_EOP] = accept;
        set_v[F_EOT] = ends_xfer;
        set_v[F_THR] = lvl_rise;
        clr_v        = clr_w1c;
        clr_v[F_EOT] = clr_w1c[F_EOT] | bus_reset;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        otx_flag_bit u_bit (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (set_v[i]),
            .clr  (clr_v[i]),
            .q    (flags[i])
        );
    end

    // Masked interrupt lines and NAK request back to the packet engine.
    always_comb begin
        irq       = flags & irq_mask;
        force_nak = flags[F_EOT];
    end
endmodule

// File: rtl/otx_checker.sv
// Property checker for the OUT transfer tracker, bound to the top module.
module otx_checker #(
    parameter int LEN_W = 7,
    parameter int LVL_W = 8,
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_reset,
    input logic             pkt_good,
    input logic [LEN_W-1:0] pkt_len,
    input logic [LEN_W-1:0] max_pkt,
    input logic [LVL_W-1:0] fifo_level,
    input logic [LVL_W-1:0] thr_level,
    input logic [2:0]       flags,
    input logic             force_nak,
    input logic [CNT_W-1:0] rem_bytes
);
    a_r2_eop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_good && !force_nak && !bus_reset) |=> flags[0]);

    a_r3_short_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_good && !force_nak && !bus_reset && pkt_len < max_pkt) |=> flags[1]);

    a_r4_full_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_good && !force_nak && !bus_reset && pkt_len >= max_pkt) |=> !flags[1]);

    a_r5_nak_freezes_count: assert property (@(posedge clk) disable iff (!rst_n)
        (force_nak && pkt_good && !bus_reset) |=> $stable(rem_bytes));

    a_r8_thr_on_crossing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $past(fifo_level > thr_level));

    a_r10_bus_reset_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!flags[1] && rem_bytes == '0));
endmodule

bind out_xfer_tracker otx_checker #(.LEN_W(LEN_W), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .pkt_good  (pkt_good),
    .pkt_len   (pkt_len),
    .max_pkt   (max_pkt),
    .fifo_level(fifo_level),
    .thr_level (thr_level),
    .flags     (flags),
    .force_nak (force_nak),
    .rem_bytes (rem_bytes)
);

// File: tb/out_xfer_tracker_test.sv
`timescale 1ns/1ps
module out_xfer_tracker_test;
    localparam int LEN_W = 7;
    localparam int LVL_W = 8;
    localparam int CNT_W = 10;

    typedef struct {
        string            req;
        logic [2:0]       fl;
        logic [2:0]       irq;
        logic             nak;
        logic [CNT_W-1:0] rem;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_reset = 1'b0, pkt_good = 1'b0;
    logic [LEN_W-1:0] pkt_len = '0, max_pkt = 7'd64;
    logic [LVL_W-1:0] fifo_level = '0, thr_level = 8'd8;
    logic [2:0]       irq_mask = 3'b111, clr_w1c = 3'b000;
    logic [2:0]       flags, irq;
    logic             force_nak;
    logic [CNT_W-1:0] rem_bytes;

    int   total = 0, bad = 0;
    bit   done = 0;
    exp_t sb[$];

    logic [2:0]       mfl  = '0;
    logic [CNT_W-1:0] mcnt = '0;
    logic             mcmp = 1'b0;

    always #4 clk = ~clk;

    out_xfer_tracker #(.LEN_W(LEN_W), .LVL_W(LVL_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .pkt_good(pkt_good),
        .pkt_len(pkt_len), .max_pkt(max_pkt), .fifo_level(fifo_level),
        .thr_level(thr_level), .irq_mask(irq_mask), .clr_w1c(clr_w1c),
        .flags(flags), .irq(irq), .force_nak(force_nak), .rem_bytes(rem_bytes)
    );

    // Driver: predict the next state from the requirements, push it, clock once.
    task automatic cyc(input string tag);
        exp_t e;
        logic acc, cmp;
        logic [2:0] nf;
        int s;
        acc = pkt_good && !mfl[1] && !bus_reset;
        nf  = mfl & ~clr_w1c;
        cmp = fifo_level > thr_level;
        if (cmp && !mcmp) nf[2] = 1'b1;
        mcmp = cmp;
        if (acc) nf[0] = 1'b1;
        if (acc && pkt_len < max_pkt) nf[1] = 1'b1;
        if (bus_reset) nf[1] = 1'b0;
        if (bus_reset || (clr_w1c[1] && mfl[1])) mcnt = '0;
        else if (acc) begin
            s = int'(mcnt) + int'(pkt_len);
            mcnt = (s > 1023) ? '1 : CNT_W'(s);
        end
        mfl = nf;
        e.req = tag; e.fl = nf; e.irq = nf & irq_mask; e.nak = nf[1]; e.rem = mcnt;
        sb.push_back(e);
        @(posedge clk);
        @(negedge clk);
        pkt_good = 1'b0; clr_w1c = 3'b000; bus_reset = 1'b0;
    endtask

    task automatic pkt(input int n, input string tag);
        pkt_good = 1'b1; pkt_len = LEN_W'(n);
        cyc(tag);
    endtask

    task automatic clr(input logic [2:0] m, input string tag);
        clr_w1c = m;
        cyc(tag);
    endtask

    // Monitor: compare each result shortly after the edge it belongs to.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (flags !== e.fl || irq !== e.irq || force_nak !== e.nak || rem_bytes !== e.rem) begin
                bad++;
                $display("FAIL %s: flags=%b irq=%b nak=%b rem=%0d expected flags=%b irq=%b nak=%b rem=%0d",
                         e.req, flags, irq, force_nak, rem_bytes, e.fl, e.irq, e.nak, e.rem);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        total++;
        if (flags !== 3'b0 || irq !== 3'b0 || force_nak !== 1'b0 || rem_bytes !== '0) begin
            bad++;
            $display("FAIL R1: flags=%b irq=%b nak=%b rem=%0d expected all zero",
                     flags, irq, force_nak, rem_bytes);
        end
        pkt(64, "R2 full packet sets end of packet");
        pkt(64, "R4 full packet keeps transfer open");
        clr(3'b001, "R7 clear end of packet");
        pkt(0,  "R3 zero-length after full ends transfer");
        pkt(10, "R5 NAKed packet ignored");
        cyc("R6 total readable while pending");
        clr(3'b010, "R7 ack end of transfer zeroes total");
        pkt(5,  "R3 short packet with no prior full");
        clr(3'b011, "R7 clear two flags");
        pkt(0,  "R3 lone zero-length packet");
        clr(3'b011, "R7 clear again");
        fifo_level = 8'd9;  cyc("R8 level crosses threshold");
        fifo_level = 8'd20; clr(3'b100, "R8 clear while above");
        cyc("R8 staying above does not re-set");
        fifo_level = 8'd3;  cyc("R8 level drops");
        fifo_level = 8'd12; clr(3'b100, "R7 set wins over clear");
        irq_mask = 3'b010;  clr(3'b101, "R9 mask hides flags");
        pkt(64, "R9 masked end of packet");
        bus_reset = 1'b1; pkt(3, "R10 bus reset overrides packet");
        pkt(3,  "R10 short packet before reset");
        bus_reset = 1'b1; cyc("R10 bus reset releases NAK");
        irq_mask = 3'b111; clr(3'b101, "R7 clear before saturation");
        for (int i = 0; i < 17; i++) pkt(64, "R6 saturating total");
        pkt(1, "R6 saturated total held at end");
        cyc("R5 NAK follows pending end");
        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule